// File: doc/BRIEF.md
# Ordered Three-Turn Dial Lock Controller

This block is a clocked Moore state machine for a dial lock that opens only after three turns have been entered in one fixed order. Each turn comes in as an entry event: `entry_valid` is high for the cycle, `entry_right` gives the turning direction, and `entry_num` gives the dial number reached. The machine only moves on a cycle that carries an entry. It holds its state on every other cycle.

The three expected turns are parameters. By default they are right to 13, then left to 22, then right to 3. The values alone do not open the lock: the same three values entered in another order, or with a wrong direction, leave it shut. A wrong turn sends the machine back to the start. The one exception is a wrong turn that is itself a valid first turn, which leaves the machine with one turn accepted.

Once open, the lock ignores further entries. It stays open until `relock` is raised or the synchronous active-low reset is applied. The current state is driven out for debug.

Top module: `combo_lock_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is idle. After that edge `state_dbg` is 2'b00 and `is_open` is 0.
- R2: `state_dbg` encodes the states as follows: idle 2'b00, first turn accepted 2'b01, first two turns accepted 2'b10, open 2'b11.
- R3: A clock edge where `entry_valid` and `relock` are both low leaves the state unchanged.
- R4: An entry moves the state up one step when it matches the expected turn for that state. The expected turns are right to 13 in state 2'b00, left to 22 in state 2'b01, and right to 3 in state 2'b10. `entry_right`=1 means right and 0 means left. The new state is visible after the edge that samples the entry.
- R5: In a non-open state, an entry that does not match the expected turn returns the state to 2'b00. The exception is an entry of right to 13, which leads to 2'b01.
- R6: `is_open` is 1 exactly when the state is 2'b11.
- R7: In state 2'b11, entries of any direction and number leave the state at 2'b11.
- R8: `relock` high at an edge while `rst_n` is high leads to state 2'b00 from any state. This holds even when an entry is presented in the same cycle.
- R9: The lock reaches 2'b11 only from 2'b10. The three code values entered in any other order or with any other direction do not open it.
- R10: Entries on consecutive cycles are each sampled, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| relock | input | 1 | Synchronous return to idle, active high |
| entry_valid | input | 1 | High on a cycle that carries one dial turn |
| entry_right | input | 1 | Turn direction: 1 right, 0 left |
| entry_num | input | DIAL_W | Dial number reached by the turn |
| is_open | output | 1 | High while the lock is open |
| state_dbg | output | 2 | Current state code for debug |

## Verification
The assertions assume three things about the inputs. They are never unknown at a clock edge. They change only between edges. Each cycle with `entry_valid` high counts as one separate turn, so a strobe held for several cycles is several turns. The bench drives every input to a defined value on the falling edge and never lets one float. It mixes directed sequences with random entries. The random entries are biased toward the three code turns and their mirrored directions, so that partial, reordered and restarted sequences occur often. Relock and reset are occasionally dropped in, including in the same cycle as an entry.

// File: rtl/combo_lock_pkg.sv
// Shared definitions for the dial lock controller.
// Assumes a two-bit state code that is also exported for debug.
package combo_lock_pkg;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'b00,
        LK_FIRST  = 2'b01,
        LK_SECOND = 2'b10,
        LK_OPEN   = 2'b11
    } lock_state_t;

    localparam int NUM_STEPS = 3;

endpackage

// File: rtl/lock_step_match.sv
// Compares one dial entry against every step of the code in parallel.
// Assumes the code is given as packed direction and number vectors,
// with step 0 in the least significant slice.
module lock_step_match #(
    parameter int                         DIAL_W    = 5,
    parameter int                         STEPS     = 3,
    parameter logic [STEPS-1:0]           STEP_DIR  = '0,
    parameter logic [STEPS*DIAL_W-1:0]    STEP_NUMS = '0
) (
    input  logic              entry_right,
    input  logic [DIAL_W-1:0] entry_num,
    output logic [STEPS-1:0]  hit
);

    genvar g;
    generate
        for (g = 0; g < STEPS; g++) begin : g_step
            // One comparator for each code step: direction and number must both agree.
            assign hit[g] = (entry_right == STEP_DIR[g]) &&
                            (entry_num == STEP_NUMS[g*DIAL_W +: DIAL_W]);
        end
    endgenerate

endmodule

// File: rtl/lock_next_state.sv
// Next-state logic of the lock. Relock wins over an entry.
// The open state ignores entries. A miss restarts the sequence, or counts
// as a first turn when it matches step 0.
// Assumes hit[k] flags a match against step k.
module lock_next_state
    import combo_lock_pkg::*;
(
    input  lock_state_t          cur,
    input  logic                 entry_valid,
    input  logic                 relock,
    input  logic [NUM_STEPS-1:0] hit,
    output lock_state_t          nxt
);

    logic expect_hit;

    // Select the comparator for the step the current state waits for.
    always_comb begin
        case (cur)
            LK_IDLE:   expect_hit = hit[0];
            LK_FIRST:  expect_hit = hit[1];
            LK_SECOND: expect_hit = hit[2];
            default:   expect_hit = 1'b0;
        endcase
    end

    // Work out the state for the next edge.
    always_comb begin
        nxt = cur;
        if (relock) begin
            nxt = LK_IDLE;
        end else if (entry_valid && cur != LK_OPEN) begin
            if (expect_hit) begin
                case (cur)
                    LK_IDLE:   nxt = LK_FIRST;
                    LK_FIRST:  nxt = LK_SECOND;
                    default:   nxt = LK_OPEN;
                endcase
            end else if (hit[0]) begin
                nxt = LK_FIRST;
            end else begin
                nxt = LK_IDLE;
            end
        end
    end

endmodule

// File: rtl/lock_state_reg.sv
// Two-bit state register with synchronous active-low reset to idle.
module lock_state_reg
    import combo_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  lock_state_t nxt,
    output lock_state_t cur
);

    // Hold the current state; reset to idle at the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= LK_IDLE;
        else        cur <= nxt;
    end

endmodule

// File: rtl/combo_lock_fsm.sv
// Top of the ordered three-turn dial lock: comparators, next-state logic
// and state register. Moore outputs decode from the register only.
// Assumes inputs are synchronous to clk and one entry per high entry_valid cycle.
module combo_lock_fsm
    import combo_lock_pkg::*;
#(
    parameter int   DIAL_W      = 5,
    parameter int   STEP0_NUM   = 13,
    parameter logic STEP0_RIGHT = 1'b1,
    parameter int   STEP1_NUM   = 22,
    parameter logic STEP1_RIGHT = 1'b0,
    parameter int   STEP2_NUM   = 3,
    parameter logic STEP2_RIGHT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              relock,
    input  logic              entry_valid,
    input  logic              entry_right,
    input  logic [DIAL_W-1:0] entry_num,
    output logic              is_open,
    output logic [1:0]        state_dbg
);

    localparam logic [NUM_STEPS-1:0] STEP_DIR =
        {STEP2_RIGHT, STEP1_RIGHT, STEP0_RIGHT};
    localparam logic [NUM_STEPS*DIAL_W-1:0] STEP_NUMS =
        {DIAL_W'(STEP2_NUM), DIAL_W'(STEP1_NUM), DIAL_W'(STEP0_NUM)};

    logic [NUM_STEPS-1:0] hit;
    lock_state_t          cur;
    lock_state_t          nxt;

    lock_step_match #(
        .DIAL_W    (DIAL_W),
        .STEPS     (NUM_STEPS),
        .STEP_DIR  (STEP_DIR),
        .STEP_NUMS (STEP_NUMS)
    ) u_match (
        .entry_right (entry_right),
        .entry_num   (entry_num),
        .hit         (hit)
    );

    lock_next_state u_next (
        .cur         (cur),
        .entry_valid (entry_valid),
        .relock      (relock),
        .hit         (hit),
        .nxt         (nxt)
    );

    lock_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    // Moore outputs taken straight from the stored state.
    assign is_open   = (cur == LK_OPEN);
    assign state_dbg = cur;

endmodule

// File: rtl/combo_lock_fsm_chk.sv
// Property checker for combo_lock_fsm, attached by bind.
// Observes ports only; the code values arrive as parameters.
module combo_lock_fsm_chk #(
    parameter int   DIAL_W      = 5,
    parameter int   STEP2_NUM   = 3,
    parameter logic STEP2_RIGHT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              relock,
    input logic              entry_valid,
    input logic              entry_right,
    input logic [DIAL_W-1:0] entry_num,
    input logic              is_open,
    input logic [1:0]        state_dbg
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (state_dbg == 2'b00 && !is_open));

    assert_hold_no_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry_valid && !relock) |=> $stable(state_dbg));

    assert_final_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_dbg == 2'b10 && entry_valid && !relock &&
         entry_right == STEP2_RIGHT && entry_num == DIAL_W'(STEP2_NUM))
        |=> (state_dbg == 2'b11));

    assert_open_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_dbg == 2'b11 && !relock) |=> (state_dbg == 2'b11));

    assert_relock_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> (state_dbg == 2'b00));

    assert_open_from_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> ($past(state_dbg) == 2'b10));

endmodule

bind combo_lock_fsm combo_lock_fsm_chk #(
    .DIAL_W      (DIAL_W),
    .STEP2_NUM   (STEP2_NUM),
    .STEP2_RIGHT (STEP2_RIGHT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .relock      (relock),
    .entry_valid (entry_valid),
    .entry_right (entry_right),
    .entry_num   (entry_num),
    .is_open     (is_open),
    .state_dbg   (state_dbg)
);

// File: tb/combo_lock_fsm_test.sv
// Bench for combo_lock_fsm: directed sequences plus seeded random entries,
// checked against a reference function written from the requirements.
module combo_lock_fsm_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          relock = 1'b0;
    logic          entry_valid = 1'b0;
    logic          entry_right = 1'b0;
    logic [DW-1:0] entry_num = '0;
    logic          is_open;
    logic [1:0]    state_dbg;

    int   checks = 0;
    int   failures = 0;
    logic [1:0] exp_state = 2'b00;

    combo_lock_fsm uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .relock      (relock),
        .entry_valid (entry_valid),
        .entry_right (entry_right),
        .entry_num   (entry_num),
        .is_open     (is_open),
        .state_dbg   (state_dbg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference next state from R1, R3, R4, R5, R7 and R8.
    function automatic logic [1:0] model(logic [1:0] s, logic rn, logic v,
                                         logic rl, logic r, logic [DW-1:0] n);
        logic m;
        if (!rn) return 2'b00;
        if (rl) return 2'b00;
        if (!v) return s;
        if (s == 2'b11) return 2'b11;
        case (s)
            2'b00:   m = r && n == 5'd13;
            2'b01:   m = !r && n == 5'd22;
            default: m = r && n == 5'd3;
        endcase
        if (m) return s + 2'b01;
        if (r && n == 5'd13) return 2'b01;
        return 2'b00;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle on the falling edge, then sample after the rising edge.
    task automatic cyc(string tag, logic rn, logic v, logic rl, logic r, logic [DW-1:0] n);
        @(negedge clk);
        rst_n = rn; entry_valid = v; relock = rl; entry_right = r; entry_num = n;
        exp_state = model(exp_state, rn, v, rl, r, n);
        @(posedge clk);
        #1;
        check(tag, int'(state_dbg), int'(exp_state));
        check("R6", int'(is_open), int'(exp_state == 2'b11));
    endtask

    task automatic turn(string tag, logic r, logic [DW-1:0] n);
        cyc(tag, 1'b1, 1'b1, 1'b0, r, n);
    endtask

    task automatic idle_cyc(string tag);
        cyc(tag, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    endtask

    bit done = 0;

    initial begin
        void'($urandom(32'd20240611));
        cyc("R1", 1'b0, 1'b0, 1'b0, 1'b0, '0);
        cyc("R1", 1'b0, 1'b1, 1'b0, 1'b1, 5'd13);
        idle_cyc("R3");
        // Correct sequence with idle gaps: encodings 01, 10, 11.
        turn("R4", 1'b1, 5'd13);
        check("R2", int'(state_dbg), 1);
        idle_cyc("R3");
        turn("R4", 1'b0, 5'd22);
        check("R2", int'(state_dbg), 2);
        idle_cyc("R3");
        turn("R4", 1'b1, 5'd3);
        check("R2", int'(state_dbg), 3);
        // Open ignores entries.
        turn("R7", 1'b1, 5'd13);
        turn("R7", 1'b0, 5'd0);
        idle_cyc("R7");
        // Relock from open.
        cyc("R8", 1'b1, 1'b0, 1'b1, 1'b0, '0);
        // Wrong order of the same values.
        turn("R9", 1'b0, 5'd22);
        turn("R9", 1'b1, 5'd13);
        turn("R9", 1'b1, 5'd3);
        turn("R9", 1'b1, 5'd3);
        check("R9", int'(is_open), 0);
        // Wrong direction on the last step.
        turn("R5", 1'b1, 5'd13);
        turn("R5", 1'b0, 5'd22);
        turn("R9", 1'b0, 5'd3);
        // Repeated first turn keeps the first step; then a miss restarts.
        turn("R5", 1'b1, 5'd13);
        turn("R5", 1'b1, 5'd13);
        turn("R5", 1'b1, 5'd13);
        turn("R5", 1'b0, 5'd13);
        // Back-to-back entries.
        turn("R10", 1'b1, 5'd13);
        turn("R10", 1'b0, 5'd22);
        turn("R10", 1'b1, 5'd3);
        // Relock with a same-cycle entry from step two.
        cyc("R8", 1'b1, 1'b0, 1'b1, 1'b0, '0);
        turn("R10", 1'b1, 5'd13);
        turn("R10", 1'b0, 5'd22);
        cyc("R8", 1'b1, 1'b1, 1'b1, 1'b1, 5'd3);
        // Reset while open.
        turn("R4", 1'b1, 5'd13);
        turn("R4", 1'b0, 5'd22);
        turn("R4", 1'b1, 5'd3);
        cyc("R1", 1'b0, 1'b1, 1'b0, 1'b1, 5'd3);
        // Random phase, biased to code turns.
        for (int i = 0; i < 4000; i++) begin
            logic [DW-1:0] n;
            int sel;
            sel = int'($urandom_range(0, 4));
            case (sel)
                0: n = 5'd13;
                1: n = 5'd22;
                2: n = 5'd3;
                default: n = DW'($urandom);
            endcase
            cyc("R5", ($urandom_range(0, 99) != 0),
                ($urandom_range(0, 3) != 0),
                ($urandom_range(0, 39) == 0),
                1'($urandom), n);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule